// File: doc/BRIEF.md
# IrDA FIFO control register unit

This unit is the FIFO side of an infrared serial port. It holds one 8-bit control and status register, reached over a simple synchronous bus. It also holds two byte FIFOs of 64 entries, one for transmit and one for receive. Each FIFO has its own push and pop ports. Line coding, baud generation and pulse shaping are handled elsewhere.

Software uses the register for four things:
- switching the FIFOs on and off;
- choosing the usable depth;
- picking the level of receive fill that raises the receive-trigger output;
- requesting a flush of either FIFO.

A flush request bit drops back to zero on its own. Each FIFO also has a sticky completion flag, which the next read of the register clears. Changing the enable bit flushes both FIFOs.

Register layout, most significant bit first:
- bits [7:6]: trigger select
- bit 5: depth select
- bit 4: transmit-clear done
- bit 3: receive-clear done
- bit 2: transmit flush
- bit 1: receive flush
- bit 0: enable

Top module: `ir_fifo_ctl_unit`

## Requirements
- R1: After reset the register reads 0x00, both fill counts are 0 and the receive trigger is low. The read data is driven combinationally while the read enable is high at the register address, and is 0 at other times.
- R2: When a write changes bit 0, both FIFOs are flushed in the next cycle. Both done flags (bit 4 transmit, bit 3 receive) then read 1. A write that leaves bit 0 unchanged flushes nothing and sets no flag.
- R3: A write with bit 0 = 0 clears the enable bit and nothing else. The trigger select (bits [7:6]) and the depth select (bit 5) keep their values, and the flush bits are not taken.
- R4: A write with bits 0 and 2 set requests a transmit flush. Bit 2 reads 1 during the cycle after the write, and the transmit FIFO is empty one cycle later. Bit 2 then reads 0, and the receive FIFO is unchanged.
- R5: A write with bits 0 and 1 set requests a receive flush in the same way. Bit 1 reads 1 for one cycle, the receive FIFO becomes empty, and the transmit FIFO is unchanged.
- R6: A done flag sets in the cycle after its flush cycle and stays set until the register is read. A read returns the flag as 1 and clears it. A read that coincides with the flush cycle leaves the flag set.
- R7: Each FIFO returns bytes in push order. Pop data is presented combinationally during the pop cycle. The fill count rises by one on each accepted push and falls by one on each accepted pop.
- R8: With bit 5 = 1 each FIFO holds 64 bytes. With bit 5 = 0 each FIFO holds 16 bytes.
- R9: The receive trigger is high when the FIFOs are enabled and the receive count is at least the selected level. Levels by trigger select 00/01/10/11:
  - 64-byte mode: 1, 16, 32, 56.
  - 16-byte mode: 1, 4, 8, 14.
- R10: A push into a full FIFO is ignored, and the overflow output of that FIFO is high in the same cycle.
- R11: A pop from an empty, enabled FIFO returns 0, and the underflow output of that FIFO is high in the same cycle.
- R12: While bit 0 is 0, pushes and pops are ignored and raise no strobe, pop data is 0, and the receive trigger stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 4 | Register address |
| busWe | input | 1 | Write enable |
| busRe | input | 1 | Read enable |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data |
| txPush | input | 1 | Push a byte into the transmit FIFO |
| txPushData | input | 8 | Byte to push into the transmit FIFO |
| txPop | input | 1 | Pop a byte from the transmit FIFO |
| txPopData | output | 8 | Byte popped from the transmit FIFO |
| txCount | output | 7 | Transmit fill count |
| txOverflow | output | 1 | Transmit push refused |
| txUnderflow | output | 1 | Transmit pop from empty |
| rxPush | input | 1 | Push a byte into the receive FIFO |
| rxPushData | input | 8 | Byte to push into the receive FIFO |
| rxPop | input | 1 | Pop a byte from the receive FIFO |
| rxPopData | output | 8 | Byte popped from the receive FIFO |
| rxCount | output | 7 | Receive fill count |
| rxOverflow | output | 1 | Receive push refused |
| rxUnderflow | output | 1 | Receive pop from empty |
| rxTrig | output | 1 | Receive fill at or above the trigger level |

## Verification
Some relations can be watched on every cycle, and the assertions cover them:
- a flush cycle leaves its FIFO empty;
- a done flag only rises right after a flush cycle, and a read with no new flush drops it;
- a change of the enable bit raises both flush strobes;
- a disabling write leaves the trigger and depth fields untouched;
- a refused push holds the count;
- an underflowing pop returns zero;
- the trigger is never high while the FIFOs are disabled.

Other behaviours depend on sequences that only the directed scenarios can build:
- byte order through each FIFO;
- the exact levels of the trigger in both depth modes;
- the 16- and 64-byte capacity limits;
- the survival of a done flag when the read coincides with the flush cycle.

// File: rtl/ir_fifo_pkg.sv
package ir_fifo_pkg;
  localparam int REG_W   = 8;
  localparam int BIT_EN  = 0;
  localparam int BIT_RXF = 1;
  localparam int BIT_TXF = 2;
  localparam int BIT_DEEP = 5;
  localparam int TRIG_LO = 6;
  localparam int TX_IDX  = 0;
  localparam int RX_IDX  = 1;

  typedef enum logic [1:0] {
    TRIG_ONE  = 2'b00,
    TRIG_QTR  = 2'b01,
    TRIG_HALF = 2'b10,
    TRIG_HIGH = 2'b11
  } trigSel_t;

  typedef struct packed {
    logic clrTx;
    logic clrRx;
  } fifoStrobes_t;
endpackage

// File: rtl/ir_byte_fifo.sv
module ir_byte_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clr,
  input  logic              en,
  input  logic [CNT_W-1:0]  cap,
  input  logic              push,
  input  logic [DATA_W-1:0] pushData,
  input  logic              pop,
  output logic [DATA_W-1:0] popData,
  output logic [CNT_W-1:0]  count,
  output logic              overflow,
  output logic              underflow
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  cnt;
  logic              full, empty, doPush, doPop;

  assign full      = cnt >= cap;
  assign empty     = cnt == '0;
  assign doPush    = en && push && !full;
  assign doPop     = en && pop && !empty;
  assign overflow  = en && push && full;
  assign underflow = en && pop && empty;
  assign popData   = doPop ? mem[rdPtr] : '0;
  assign count     = cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      cnt <= cnt + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !clr) mem[wrPtr] <= pushData;
  end

  // R4 / R5: a flush cycle leaves the FIFO empty
  p_clear_empties_r4: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (count == '0));
  // R10: refused push leaves the count alone
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !pop && !clr) |=> (count == $past(count)));
  // R11: underflowing pop returns zero
  p_underflow_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    underflow |-> (popData == '0));
  // R8: count never exceeds storage
  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/ir_fifo_dp.sv
module ir_fifo_dp
  import ir_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  fifoStrobes_t           stb,
  input  logic                   fifoEn,
  input  logic [CNT_W-1:0]       cap,
  input  logic [1:0]             push,
  input  logic [1:0][DATA_W-1:0] pushData,
  input  logic [1:0]             pop,
  output logic [1:0][DATA_W-1:0] popData,
  output logic [1:0][CNT_W-1:0]  count,
  output logic [1:0]             overflow,
  output logic [1:0]             underflow
);
  logic [1:0] clrVec;
  assign clrVec[TX_IDX] = stb.clrTx;
  assign clrVec[RX_IDX] = stb.clrRx;

  for (genvar g = 0; g < 2; g++) begin : gFifo
    ir_byte_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uFifo (
      .clk       (clk),
      .rstN      (rstN),
      .clr       (clrVec[g]),
      .en        (fifoEn),
      .cap       (cap),
      .push      (push[g]),
      .pushData  (pushData[g]),
      .pop       (pop[g]),
      .popData   (popData[g]),
      .count     (count[g]),
      .overflow  (overflow[g]),
      .underflow (underflow[g])
    );
  end
endmodule

// File: rtl/ir_fifo_ctl.sv
module ir_fifo_ctl
  import ir_fifo_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0,
  parameter int DEPTH    = 64,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int SHALLOW = DEPTH / 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  input  logic [CNT_W-1:0]  rxCount,
  output fifoStrobes_t      stb,
  output logic              fifoEn,
  output logic [CNT_W-1:0]  cap,
  output logic              rxTrig
);
  logic       wrHit, rdHit, enToggle;
  logic       enQ, deepQ, clrTxQ, clrRxQ, doneTxQ, doneRxQ;
  trigSel_t   trigQ;
  logic [CNT_W-1:0] level;

  assign wrHit    = busWe && (busAddr == ADDR_W'(REG_ADDR));
  assign rdHit    = busRe && (busAddr == ADDR_W'(REG_ADDR));
  assign enToggle = wrHit && (busWdata[BIT_EN] != enQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ     <= 1'b0;
      deepQ   <= 1'b0;
      trigQ   <= TRIG_ONE;
      clrTxQ  <= 1'b0;
      clrRxQ  <= 1'b0;
      doneTxQ <= 1'b0;
      doneRxQ <= 1'b0;
    end else begin
      if (wrHit) begin
        enQ <= busWdata[BIT_EN];
        if (busWdata[BIT_EN]) begin
          trigQ <= trigSel_t'(busWdata[TRIG_LO+1:TRIG_LO]);
          deepQ <= busWdata[BIT_DEEP];
        end
      end
      clrTxQ  <= enToggle || (wrHit && busWdata[BIT_EN] && busWdata[BIT_TXF]);
      clrRxQ  <= enToggle || (wrHit && busWdata[BIT_EN] && busWdata[BIT_RXF]);
      doneTxQ <= clrTxQ || (doneTxQ && !rdHit);
      doneRxQ <= clrRxQ || (doneRxQ && !rdHit);
    end
  end

  assign busRdata = rdHit ? {trigQ, deepQ, doneTxQ, doneRxQ, clrTxQ, clrRxQ, enQ} : '0;

  assign cap = deepQ ? CNT_W'(DEPTH) : CNT_W'(SHALLOW);

  always_comb begin
    unique case (trigQ)
      TRIG_ONE:  level = CNT_W'(1);
      TRIG_QTR:  level = cap >> 2;
      TRIG_HALF: level = cap >> 1;
      TRIG_HIGH: level = cap - (cap >> 3);
      default:   level = CNT_W'(1);
    endcase
  end

  assign rxTrig    = enQ && (rxCount >= level);
  assign fifoEn    = enQ;
  assign stb.clrTx = clrTxQ;
  assign stb.clrRx = clrRxQ;

  // R2: changing the enable flushes both FIFOs
  p_toggle_flush_r2: assert property (@(posedge clk) disable iff (!rstN)
    enToggle |=> (stb.clrTx && stb.clrRx));
  // R3: disabling write keeps trigger and depth fields
  p_fields_kept_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && !busWdata[BIT_EN]) |=> ($stable(trigQ) && $stable(deepQ)));
  // R4: flush request drops by itself
  p_selfclear_r4: assert property (@(posedge clk) disable iff (!rstN)
    (clrTxQ && !wrHit) |=> !clrTxQ);
  // R6: done flag rises only after a flush cycle
  p_done_after_flush_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneTxQ) |-> $past(clrTxQ));
  // R6: read drops the done flag when no flush coincides
  p_read_drops_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdHit && doneRxQ && !clrRxQ) |=> !doneRxQ);
  // R9 / R12: no trigger while disabled
  p_trig_enabled_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxTrig |-> fifoEn);
endmodule

// File: rtl/ir_fifo_ctl_unit.sv
module ir_fifo_ctl_unit
  import ir_fifo_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0,
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 64,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  input  logic              txPush,
  input  logic [DATA_W-1:0] txPushData,
  input  logic              txPop,
  output logic [DATA_W-1:0] txPopData,
  output logic [CNT_W-1:0]  txCount,
  output logic              txOverflow,
  output logic              txUnderflow,
  input  logic              rxPush,
  input  logic [DATA_W-1:0] rxPushData,
  input  logic              rxPop,
  output logic [DATA_W-1:0] rxPopData,
  output logic [CNT_W-1:0]  rxCount,
  output logic              rxOverflow,
  output logic              rxUnderflow,
  output logic              rxTrig
);
  fifoStrobes_t           stb;
  logic                   fifoEn;
  logic [CNT_W-1:0]       cap;
  logic [1:0]             pushVec, popVec, ovfVec, udfVec;
  logic [1:0][DATA_W-1:0] pushDataVec, popDataVec;
  logic [1:0][CNT_W-1:0]  countVec;

  assign pushVec     = {rxPush, txPush};
  assign popVec      = {rxPop, txPop};
  assign pushDataVec = {rxPushData, txPushData};
  assign txPopData   = popDataVec[TX_IDX];
  assign rxPopData   = popDataVec[RX_IDX];
  assign txCount     = countVec[TX_IDX];
  assign rxCount     = countVec[RX_IDX];
  assign txOverflow  = ovfVec[TX_IDX];
  assign rxOverflow  = ovfVec[RX_IDX];
  assign txUnderflow = udfVec[TX_IDX];
  assign rxUnderflow = udfVec[RX_IDX];

  ir_fifo_ctl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .DEPTH(DEPTH)) uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWe    (busWe),
    .busRe    (busRe),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .rxCount  (countVec[RX_IDX]),
    .stb      (stb),
    .fifoEn   (fifoEn),
    .cap      (cap),
    .rxTrig   (rxTrig)
  );

  ir_fifo_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .fifoEn    (fifoEn),
    .cap       (cap),
    .push      (pushVec),
    .pushData  (pushDataVec),
    .pop       (popVec),
    .popData   (popDataVec),
    .count     (countVec),
    .overflow  (ovfVec),
    .underflow (udfVec)
  );
endmodule

// File: tb/tb_ir_fifo_ctl_unit.sv
module tb_ir_fifo_ctl_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic       busWe = 1'b0, busRe = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       txPush = 1'b0, txPop = 1'b0, rxPush = 1'b0, rxPop = 1'b0;
  logic [7:0] txPushData = '0, rxPushData = '0;
  logic [7:0] txPopData, rxPopData;
  logic [6:0] txCount, rxCount;
  logic       txOverflow, txUnderflow, rxOverflow, rxUnderflow, rxTrig;

  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ir_fifo_ctl_unit dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata),
    .txPush(txPush), .txPushData(txPushData), .txPop(txPop), .txPopData(txPopData),
    .txCount(txCount), .txOverflow(txOverflow), .txUnderflow(txUnderflow),
    .rxPush(rxPush), .rxPushData(rxPushData), .rxPop(rxPop), .rxPopData(rxPopData),
    .rxCount(rxCount), .rxOverflow(rxOverflow), .rxUnderflow(rxUnderflow),
    .rxTrig(rxTrig)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] v);
    @(negedge clk);
    busWe = 1'b1; busWdata = v;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic readNow(output logic [7:0] v);
    busRe = 1'b1;
    #1 v = busRdata;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic regRead(output logic [7:0] v);
    @(negedge clk);
    readNow(v);
  endtask

  task automatic pushOp(input int idx, input logic [7:0] d, output bit ovf);
    @(negedge clk);
    if (idx == 0) begin txPush = 1'b1; txPushData = d; end
    else begin rxPush = 1'b1; rxPushData = d; end
    #1 ovf = (idx == 0) ? txOverflow : rxOverflow;
    @(negedge clk);
    txPush = 1'b0; rxPush = 1'b0;
  endtask

  task automatic popOp(input int idx, output logic [7:0] d, output bit udf);
    @(negedge clk);
    if (idx == 0) txPop = 1'b1; else rxPop = 1'b1;
    #1;
    d   = (idx == 0) ? txPopData : rxPopData;
    udf = (idx == 0) ? txUnderflow : rxUnderflow;
    @(negedge clk);
    txPop = 1'b0; rxPop = 1'b0;
  endtask

  task automatic testReset();
    logic [7:0] v;
    regRead(v);
    chk("R1 reset value", v, 8'h00);
    chk("R1 tx count", txCount, 0);
    chk("R1 rx count", rxCount, 0);
    chk("R1 trigger", rxTrig, 0);
    busAddr = 4'h3; busRe = 1'b1;
    #1 chk("R1 off-address read", busRdata, 0);
    busRe = 1'b0; busAddr = 4'h0;
  endtask

  task automatic testEnable();
    logic [7:0] v;
    regWrite(8'h21);
    regRead(v);
    chk("R2 toggle sets both done flags", v, 8'h39);
    regRead(v);
    chk("R6 read clears flags", v, 8'h21);
  endtask

  task automatic testOrder();
    logic [7:0] d; bit f;
    pushOp(0, 8'hA1, f); pushOp(0, 8'hB2, f); pushOp(0, 8'hC3, f);
    chk("R7 count after pushes", txCount, 3);
    popOp(0, d, f); chk("R7 first byte", d, 8'hA1);
    popOp(0, d, f); chk("R7 second byte", d, 8'hB2);
    popOp(0, d, f); chk("R7 third byte", d, 8'hC3);
    chk("R7 count after pops", txCount, 0);
  endtask

  task automatic testTxFlush();
    logic [7:0] v; bit f;
    pushOp(0, 8'h10, f); pushOp(0, 8'h11, f);
    pushOp(1, 8'h20, f); pushOp(1, 8'h21, f);
    regWrite(8'h25);
    readNow(v);
    chk("R4 flush bit visible", v, 8'h25);
    chk("R4 tx emptied", txCount, 0);
    chk("R4 rx untouched", rxCount, 2);
    regRead(v);
    chk("R6 flag kept across coinciding read", v, 8'h31);
    regRead(v);
    chk("R4 flush bit self-clears", v, 8'h21);
  endtask

  task automatic testRxFlush();
    logic [7:0] v; logic [7:0] d; bit f;
    pushOp(0, 8'h55, f);
    regWrite(8'h23);
    readNow(v);
    chk("R5 flush bit visible", v, 8'h23);
    chk("R5 rx emptied", rxCount, 0);
    chk("R5 tx untouched", txCount, 1);
    regRead(v);
    chk("R5 rx done flag", v, 8'h29);
    regRead(v);
    chk("R5 flags cleared", v, 8'h21);
    popOp(0, d, f);
    chk("R5 tx byte survives", d, 8'h55);
  endtask

  task automatic testDeepTrigger();
    logic [7:0] v; logic [7:0] d; bit f;
    regWrite(8'h61);
    regRead(v);
    chk("R2 no flush when enable unchanged", v, 8'h61);
    for (int k = 0; k < 15; k++) pushOp(1, 8'(8'h40 + k), f);
    chk("R9 below level 16", rxTrig, 0);
    pushOp(1, 8'h4F, f);
    chk("R9 at level 16", rxTrig, 1);
    regWrite(8'h21);
    chk("R9 level 1", rxTrig, 1);
    regWrite(8'hA1);
    chk("R9 level 32 not reached", rxTrig, 0);
    for (int k = 16; k < 32; k++) pushOp(1, 8'(8'h40 + k), f);
    chk("R9 level 32 reached", rxTrig, 1);
    regWrite(8'hE1);
    chk("R9 level 56 not reached", rxTrig, 0);
    for (int k = 32; k < 56; k++) pushOp(1, 8'(8'h40 + k), f);
    chk("R9 level 56 reached", rxTrig, 1);
    for (int k = 56; k < 64; k++) pushOp(1, 8'(8'h40 + k), f);
    chk("R8 deep capacity", rxCount, 64);
    pushOp(1, 8'hEE, f);
    chk("R10 overflow strobe", f, 1);
    chk("R10 count held", rxCount, 64);
    for (int k = 0; k < 64; k++) begin
      popOp(1, d, f);
      chk("R7 deep order", d, 8'h40 + k);
    end
    popOp(1, d, f);
    chk("R11 underflow data", d, 0);
    chk("R11 underflow strobe", f, 1);
  endtask

  task automatic testShallow();
    bit f;
    regWrite(8'h01);
    for (int k = 0; k < 16; k++) pushOp(0, 8'(k), f);
    chk("R8 shallow fill", txCount, 16);
    pushOp(0, 8'h99, f);
    chk("R8 shallow overflow", f, 1);
    chk("R8 shallow capacity", txCount, 16);
    regWrite(8'h41);
    for (int k = 0; k < 3; k++) pushOp(1, 8'(k), f);
    chk("R9 shallow below 4", rxTrig, 0);
    pushOp(1, 8'h03, f);
    chk("R9 shallow at 4", rxTrig, 1);
  endtask

  task automatic testDisableWrite();
    logic [7:0] v;
    regWrite(8'hE6);
    regRead(v);
    chk("R3 fields kept on disable", v, 8'h58);
    chk("R2 disable flushes tx", txCount, 0);
    chk("R2 disable flushes rx", rxCount, 0);
    regRead(v);
    chk("R3 settled value", v, 8'h40);
  endtask

  task automatic testDisabledOps();
    logic [7:0] v; logic [7:0] d; bit f;
    pushOp(0, 8'h77, f);
    chk("R12 no overflow when off", f, 0);
    chk("R12 push ignored", txCount, 0);
    popOp(1, d, f);
    chk("R12 pop data zero", d, 0);
    chk("R12 no underflow when off", f, 0);
    chk("R12 trigger low", rxTrig, 0);
    regWrite(8'h00);
    regRead(v);
    chk("R2 no flush on unchanged disable", v, 8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testEnable();
    testOrder();
    testTxFlush();
    testRxFlush();
    testDeepTrigger();
    testShallow();
    testDisableWrite();
    testDisabledOps();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChk++; nBad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end
endmodule